// File: doc/BRIEF.md
# In-Order Retirement Back End with Pipelined Floating-Point Unit

This block tracks instructions through a small two-wide back end. Up to two instructions arrive each cycle on a dispatch port, the lower slot being the older one. Each carries a 4-bit tag and a class bit (integer or floating-point). Integer work needs one execute cycle. Floating-point work passes through a three-stage execute pipe that accepts one new operation every clock.

Every accepted instruction takes an entry in an eight-entry reorder queue. The queue retires finished entries from its head, at most two per cycle, and strictly in program order. An integer result that finishes early therefore stays in the queue until every older floating-point operation has finished. It then retires in the same cycle as the operation it was waiting for, provided it falls within the two-per-cycle limit.

The retire strobes and tags let a surrounding model or a testbench see both the program order and the exact retire cycle. No arithmetic is modelled; only the timing of stages and retirement is.

Top module: `inorder_retire_core`

## Requirements
- R1: A synchronous active-high reset empties the queue and every execute stage. After reset no retire strobe is raised, even for instructions that were in flight, and `disp_rdy` is 2'b11 while no dispatch is offered.
- R2: An integer instruction accepted in cycle N, with nothing older pending, shows its retire strobe and tag in cycle N+2 for exactly one cycle.
- R3: A floating-point instruction accepted in cycle N, with nothing older pending, retires in cycle N+4. Floating-point instructions accepted on consecutive cycles retire on consecutive cycles.
- R4: An integer instruction never retires before an older floating-point instruction. When it has already finished, it retires in the same cycle as the last older floating-point instruction, on the lane after it.
- R5: At most two instructions retire per cycle, taken from the queue head. `ret_tag[0]` is always older than `ret_tag[1]`, and `ret_vld` is 2'b01 or 2'b11 whenever anything retires.
- R6: When both dispatch slots offer a floating-point instruction in the same cycle, only slot 0 is accepted (`disp_rdy` = 2'b01). Slot 1 must be offered again in a later cycle.
- R7: The queue holds 8 entries. `disp_rdy[0]` is low when the queue is full. `disp_rdy[1]` is low unless a free entry exists for slot 1 after slot 0 has taken its own entry. An instruction offered while its ready bit is low is not accepted and never retires.
- R8: When dispatch stops, every held instruction retires, in order, once the last floating-point instruction finishes. After that no further strobe appears.
- R9: A dispatch with only slot 1 valid (`disp_vld` = 2'b10) is accepted and retires through the queue like any other instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| disp_vld | input | 2 | Per-slot dispatch valid; bit 0 is the older slot |
| disp_fp | input | 2 | Per-slot class: 1 = floating-point, 0 = integer |
| disp_tag | input | 2x4 | Per-slot instruction tag |
| disp_rdy | output | 2 | Per-slot accept; a slot is taken when its valid and ready bits are both high |
| ret_vld | output | 2 | Retire strobes; lane 0 is the older one |
| ret_tag | output | 2x4 | Tags of the retiring instructions |

## Verification
A mixed stream is run first: integer pairs, back-to-back floating-point pairs, and integers that follow floating-point work. Its retire pattern separates a design that retires out of order, or that retires held integers a cycle late, from a correct one. It also shows the two-per-cycle limit when three finished entries sit at the head. A queue-filling sequence checks that a full queue refuses dispatch and that refused instructions never appear at retire. A run of single floating-point operations on consecutive cycles, with the last one offered on slot 1 alone, checks the pipe's one-per-clock throughput and the use of slot 1 by itself. A reset issued while work is in flight must erase that work.

// File: rtl/inorder_pkg.sv
package inorder_pkg;
    parameter int TAG_W     = 4;
    parameter int Q_DEPTH   = 8;
    parameter int FP_STAGES = 3;
    parameter int INT_STAGES = 1;
    parameter int NSLOT     = 2;

    localparam int IDX_W = $clog2(Q_DEPTH);
    localparam int CNT_W = $clog2(Q_DEPTH + 1);
    localparam int NMARK = NSLOT + 1;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/exec_pipe.sv
module exec_pipe #(
    parameter int LANES  = 1,
    parameter int STAGES = 3,
    parameter int IW     = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [LANES-1:0]           in_vld,
    input  logic [LANES-1:0][IW-1:0]   in_idx,
    output logic [LANES-1:0]           out_vld,
    output logic [LANES-1:0][IW-1:0]   out_idx
);
    typedef struct packed {
        logic [STAGES-1:0][LANES-1:0]         vld;
        logic [STAGES-1:0][LANES-1:0][IW-1:0] idx;
    } pipe_st_t;

    pipe_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.vld[0] = in_vld;
        st_d.idx[0] = in_idx;
        for (int s = 1; s < STAGES; s++) begin
            st_d.vld[s] = st_q.vld[s-1];
            st_d.idx[s] = st_q.idx[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_vld = st_q.vld[STAGES-1];
    assign out_idx = st_q.idx[STAGES-1];

    // R2 (integer pipe) and R3 (floating-point pipe): fixed stage latency
    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        a_r3_stage_latency: assert property (@(posedge clk) disable iff (rst)
            out_vld[l] |-> $past(in_vld[l], STAGES))
            else $error("pipe lane %0d left without an entry %0d cycles earlier", l, STAGES);
    end
endmodule

// File: rtl/rob_queue.sv
module rob_queue
    import inorder_pkg::*;
#(
    parameter int DEPTH = Q_DEPTH,
    parameter int TW    = TAG_W,
    parameter int NM    = NMARK
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [1:0]                        alloc_vld,
    input  logic [1:0][TW-1:0]                alloc_tag,
    output logic [1:0][$clog2(DEPTH)-1:0]     alloc_idx,
    output logic [$clog2(DEPTH+1)-1:0]        free_cnt,
    input  logic [NM-1:0]                     mark_vld,
    input  logic [NM-1:0][$clog2(DEPTH)-1:0]  mark_idx,
    output logic [1:0]                        ret_vld,
    output logic [1:0][TW-1:0]                ret_tag
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][TW-1:0] tag;
        logic [DEPTH-1:0]         done;
        logic [IW-1:0]            head;
        logic [IW-1:0]            tail;
        logic [CW-1:0]            count;
    } q_st_t;

    q_st_t st_d, st_q;

    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic [IW-1:0] head_1;
    logic [1:0]    n_alloc, n_ret;

    always_comb begin
        head_1     = nxt(st_q.head);
        ret_vld[0] = (st_q.count != '0) && st_q.done[st_q.head];
        ret_vld[1] = ret_vld[0] && (st_q.count > CW'(1)) && st_q.done[head_1];
        ret_tag[0] = st_q.tag[st_q.head];
        ret_tag[1] = st_q.tag[head_1];

        alloc_idx[0] = st_q.tail;
        alloc_idx[1] = alloc_vld[0] ? nxt(st_q.tail) : st_q.tail;
        free_cnt     = CW'(DEPTH) - st_q.count;

        n_alloc = {1'b0, alloc_vld[0]} + {1'b0, alloc_vld[1]};
        n_ret   = {1'b0, ret_vld[0]} + {1'b0, ret_vld[1]};

        st_d = st_q;
        for (int m = 0; m < NM; m++) begin
            if (mark_vld[m]) st_d.done[mark_idx[m]] = 1'b1;
        end
        for (int a = 0; a < 2; a++) begin
            if (alloc_vld[a]) begin
                st_d.tag[alloc_idx[a]]  = alloc_tag[a];
                st_d.done[alloc_idx[a]] = 1'b0;
            end
        end
        if (n_ret == 2'd2)      st_d.head = nxt(head_1);
        else if (n_ret == 2'd1) st_d.head = head_1;
        if (n_alloc == 2'd2)      st_d.tail = nxt(nxt(st_q.tail));
        else if (n_alloc == 2'd1) st_d.tail = nxt(st_q.tail);
        st_d.count = st_q.count + CW'(n_alloc) - CW'(n_ret);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R7: occupancy never passes the queue depth
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        st_q.count <= CW'(DEPTH))
        else $error("queue occupancy above depth");

    // R7: the dispatch side never asks for more entries than are free
    a_r7_alloc_fits: assert property (@(posedge clk) disable iff (rst)
        CW'($countones(alloc_vld)) <= free_cnt)
        else $error("allocation beyond free entries");

    // R4: an execute pipe only finishes entries that are still pending
    for (genvar m = 0; m < NM; m++) begin : g_mark_chk
        a_r4_mark_pending: assert property (@(posedge clk) disable iff (rst)
            mark_vld[m] |-> !st_q.done[mark_idx[m]])
            else $error("finish mark on an entry already done");
    end
endmodule

// File: rtl/inorder_retire_core.sv
module inorder_retire_core
    import inorder_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NSLOT-1:0]            disp_vld,
    input  logic [NSLOT-1:0]            disp_fp,
    input  logic [NSLOT-1:0][TAG_W-1:0] disp_tag,
    output logic [NSLOT-1:0]            disp_rdy,
    output logic [1:0]                  ret_vld,
    output logic [1:0][TAG_W-1:0]       ret_tag
);
    logic [NSLOT-1:0]            acc;
    logic [1:0][IDX_W-1:0]       slot_idx;
    cnt_t                        free_cnt;
    cnt_t                        need_1;
    logic                        fp_pair;
    logic [0:0]                  fp_in_vld, fp_out_vld;
    logic [0:0][IDX_W-1:0]       fp_in_idx, fp_out_idx;
    logic [NSLOT-1:0]            int_in_vld, int_out_vld;
    logic [NSLOT-1:0][IDX_W-1:0] int_out_idx;
    logic [NMARK-1:0]            mark_vld;
    logic [NMARK-1:0][IDX_W-1:0] mark_idx;

    always_comb begin
        fp_pair     = disp_vld[0] && disp_fp[0] && disp_fp[1];
        need_1      = disp_vld[0] ? CNT_W'(2) : CNT_W'(1);
        disp_rdy[0] = (free_cnt != '0);
        disp_rdy[1] = (free_cnt >= need_1) && !fp_pair;
        acc         = disp_vld & disp_rdy;

        int_in_vld   = acc & ~disp_fp;
        fp_in_vld[0] = (acc[0] && disp_fp[0]) || (acc[1] && disp_fp[1]);
        fp_in_idx[0] = (acc[0] && disp_fp[0]) ? slot_idx[0] : slot_idx[1];

        mark_vld = {fp_out_vld[0], int_out_vld};
        mark_idx = {fp_out_idx[0], int_out_idx};
    end

    exec_pipe #(.LANES(NSLOT), .STAGES(INT_STAGES), .IW(IDX_W)) u_int_pipe (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (int_in_vld),
        .in_idx  (slot_idx),
        .out_vld (int_out_vld),
        .out_idx (int_out_idx)
    );

    exec_pipe #(.LANES(1), .STAGES(FP_STAGES), .IW(IDX_W)) u_fp_pipe (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (fp_in_vld),
        .in_idx  (fp_in_idx),
        .out_vld (fp_out_vld),
        .out_idx (fp_out_idx)
    );

    rob_queue #(.DEPTH(Q_DEPTH), .TW(TAG_W), .NM(NMARK)) u_rob (
        .clk       (clk),
        .rst       (rst),
        .alloc_vld (acc),
        .alloc_tag (disp_tag),
        .alloc_idx (slot_idx),
        .free_cnt  (free_cnt),
        .mark_vld  (mark_vld),
        .mark_idx  (mark_idx),
        .ret_vld   (ret_vld),
        .ret_tag   (ret_tag)
    );

    // R6: two floating-point offers in one cycle never both get accepted
    a_r6_single_fp_entry: assert property (@(posedge clk) disable iff (rst)
        (disp_vld[0] && disp_vld[1] && disp_fp[0] && disp_fp[1]) |-> !disp_rdy[1])
        else $error("second floating-point slot accepted in same cycle");

    // R7: a full queue refuses slot 0
    a_r7_full_blocks: assert property (@(posedge clk) disable iff (rst)
        (free_cnt == '0) |-> !disp_rdy[0])
        else $error("dispatch ready while queue full");

    // R5: the younger lane never retires alone
    a_r5_lane_order: assert property (@(posedge clk) disable iff (rst)
        ret_vld[1] |-> ret_vld[0])
        else $error("lane 1 retired without lane 0");
endmodule

// File: tb/inorder_retire_core_bench.sv
module inorder_retire_core_bench;
    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      disp_vld = '0;
    logic [1:0]      disp_fp  = '0;
    logic [1:0][3:0] disp_tag = '0;
    logic [1:0]      disp_rdy;
    logic [1:0]      ret_vld;
    logic [1:0][3:0] ret_tag;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    inorder_retire_core u_inorder_retire_core (
        .clk      (clk),
        .rst      (rst),
        .disp_vld (disp_vld),
        .disp_fp  (disp_fp),
        .disp_tag (disp_tag),
        .disp_rdy (disp_rdy),
        .ret_vld  (ret_vld),
        .ret_tag  (ret_tag)
    );

    typedef struct packed {
        logic [1:0] vld;
        logic [1:0] fp;
        logic [3:0] t0;
        logic [3:0] t1;
        logic [1:0] e_rdy;
        logic [1:0] e_ret;
        logic [3:0] e_t0;
        logic [3:0] e_t1;
        logic [3:0] req;
    } vec_t;

    // Mixed stream: rows are consecutive cycles (vld/fp bit 0 = older slot).
    localparam vec_t TBL [11] = '{
        '{2'b11, 2'b00, 4'd1, 4'd2, 2'b11, 2'b00, 4'd0, 4'd0, 4'd2}, // R2 int pair
        '{2'b11, 2'b11, 4'd3, 4'd4, 2'b01, 2'b00, 4'd0, 4'd0, 4'd6}, // R6 fp pair split
        '{2'b11, 2'b01, 4'd4, 4'd5, 2'b11, 2'b11, 4'd1, 4'd2, 4'd2}, // R2 pair retires
        '{2'b11, 2'b00, 4'd6, 4'd7, 2'b11, 2'b00, 4'd0, 4'd0, 4'd4}, // R4 int held
        '{2'b11, 2'b11, 4'd8, 4'd9, 2'b01, 2'b00, 4'd0, 4'd0, 4'd6}, // R6 again
        '{2'b01, 2'b01, 4'd9, 4'd0, 2'b11, 2'b01, 4'd3, 4'd0, 4'd3}, // R3 fp at +4
        '{2'b00, 2'b00, 4'd0, 4'd0, 2'b11, 2'b11, 4'd4, 4'd5, 4'd4}, // R4 int with fp
        '{2'b00, 2'b00, 4'd0, 4'd0, 2'b11, 2'b11, 4'd6, 4'd7, 4'd5}, // R5 limit two
        '{2'b00, 2'b00, 4'd0, 4'd0, 2'b11, 2'b01, 4'd8, 4'd0, 4'd8}, // R8 drain
        '{2'b00, 2'b00, 4'd0, 4'd0, 2'b11, 2'b01, 4'd9, 4'd0, 4'd8}, // R8 drain
        '{2'b00, 2'b00, 4'd0, 4'd0, 2'b11, 2'b00, 4'd0, 4'd0, 4'd8}  // R8 empty
    };

    task automatic drive(input logic [1:0] v, input logic [1:0] f,
                         input logic [3:0] a, input logic [3:0] b);
        @(posedge clk);
        #1;
        disp_vld = v;
        disp_fp  = f;
        disp_tag = {b, a};
        #2;
    endtask

    task automatic check(input logic [1:0] e_rdy, input logic [1:0] e_ret,
                         input logic [3:0] e0, input logic [3:0] e1,
                         input string req);
        bit bad;
        bad = (disp_rdy !== e_rdy) || (ret_vld !== e_ret)
              || (e_ret[0] && ret_tag[0] !== e0)
              || (e_ret[1] && ret_tag[1] !== e1);
        n_run++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: rdy=%b ret=%b tags=%0d,%0d expected rdy=%b ret=%b tags=%0d,%0d",
                     req, disp_rdy, ret_vld, ret_tag[0], ret_tag[1], e_rdy, e_ret, e0, e1);
        end
    endtask

    task automatic idle_check(input logic [1:0] e_ret, input logic [3:0] e0,
                              input logic [3:0] e1, input string req);
        drive(2'b00, 2'b00, 4'd0, 4'd0);
        check(2'b11, e_ret, e0, e1, req);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        disp_vld = '0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1: empty after reset
        #2;
        check(2'b11, 2'b00, 4'd0, 4'd0, "R1 reset state");

        for (int i = 0; i < 11; i++) begin
            drive(TBL[i].vld, TBL[i].fp, TBL[i].t0, TBL[i].t1);
            check(TBL[i].e_rdy, TBL[i].e_ret, TBL[i].e_t0, TBL[i].e_t1,
                  $sformatf("R%0d table row %0d", TBL[i].req, i));
        end

        // R7: fill the queue behind an fp op, then offer more
        do_reset();
        drive(2'b11, 2'b01, 4'd0, 4'd1);  check(2'b11, 2'b00, 4'd0, 4'd0, "R7 fill c0");
        drive(2'b11, 2'b00, 4'd2, 4'd3);  check(2'b11, 2'b00, 4'd0, 4'd0, "R7 fill c1");
        drive(2'b11, 2'b00, 4'd4, 4'd5);  check(2'b11, 2'b00, 4'd0, 4'd0, "R4 fill c2");
        drive(2'b11, 2'b00, 4'd6, 4'd7);  check(2'b11, 2'b00, 4'd0, 4'd0, "R7 fill c3");
        drive(2'b11, 2'b00, 4'd8, 4'd9);  check(2'b00, 2'b11, 4'd0, 4'd1, "R7 full refuses");
        idle_check(2'b11, 4'd2, 4'd3, "R5 drain pair");
        idle_check(2'b11, 4'd4, 4'd5, "R5 drain pair");
        idle_check(2'b11, 4'd6, 4'd7, "R8 drain pair");
        idle_check(2'b00, 4'd0, 4'd0, "R7 refused never retires");

        // R1: reset while an fp op is in flight
        drive(2'b01, 2'b01, 4'd10, 4'd0); check(2'b11, 2'b00, 4'd0, 4'd0, "R1 pre-reset dispatch");
        do_reset();
        #2;
        check(2'b11, 2'b00, 4'd0, 4'd0, "R1 after reset");
        idle_check(2'b00, 4'd0, 4'd0, "R1 flushed op");
        idle_check(2'b00, 4'd0, 4'd0, "R1 flushed op");
        idle_check(2'b00, 4'd0, 4'd0, "R1 flushed op");

        // R3 throughput and R9 slot-1-only dispatch
        drive(2'b01, 2'b01, 4'd11, 4'd0); check(2'b11, 2'b00, 4'd0, 4'd0, "R3 fp A");
        drive(2'b01, 2'b01, 4'd12, 4'd0); check(2'b11, 2'b00, 4'd0, 4'd0, "R3 fp B");
        drive(2'b10, 2'b10, 4'd0, 4'd13); check(2'b11, 2'b00, 4'd0, 4'd0, "R9 slot1 only");
        idle_check(2'b00, 4'd0, 4'd0, "R3 not yet");
        idle_check(2'b01, 4'd11, 4'd0, "R3 fp A at +4");
        idle_check(2'b01, 4'd12, 4'd0, "R3 fp B next cycle");
        idle_check(2'b01, 4'd13, 4'd0, "R9 slot1 op retires");
        idle_check(2'b00, 4'd0, 4'd0, "R8 empty");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule